// File: doc/BRIEF.md
# Running Checksum and Tag Verifier

This unit sits beside the two block-cipher layers of a pipelined, nonce-misuse-resistant authenticated cipher and owns the message checksum. While encrypting, it folds every plaintext block into a 128-bit XOR sum. When the final block is shorter than a full block, the unit pads it before folding it in: one set bit goes right after the data and the remaining bits are cleared. At the end of the message, the finished sum is presented as one extra block. That block travels down the same pipeline and produces the tag. The unit also carries the small steering step at the input of the decryption layer. For the tag-producing call, that step flips the lowest bit of the mixing output.

While decrypting, the same folding is applied to the recovered plaintext blocks in a second, separate sum. The received tag block arrives after the last ciphertext block. The decryption core's output for that tag block is compared bit for bit with the recovered-plaintext sum. The outcome is given as a one-cycle valid pulse and a pass flag. The pass flag holds its value until the next message starts.

Top module: `cksum_verify`

## Requirements
- R1: After reset, `chk_o`, `chk_valid_o`, `vld_o` and `pass_o` are all zero.
- R2: A cycle with `start_i` high clears both sums and `pass_o`, and suppresses `chk_valid_o` and `vld_o` on the next cycle. A block or tag offered in that same cycle is discarded.
- R3: Each accepted block (`blk_valid_i` high) is XORed into the sum chosen by `mode_dec_i` (0 selects the encrypt sum, 1 selects the decrypt sum). `chk_o` shows the sum of the currently selected mode.
- R4: On a block with `blk_last_i` high and `blk_bytes_i` = n, where 1 ≤ n ≤ 15, the following applies. Byte 0 sits at bits 127:120. Bytes 0 to n-1 are kept, byte n becomes 8'h80, and every later byte becomes zero before the block is folded in.
- R5: A last block with `blk_bytes_i` = 0 is folded in unpadded. On any block that is not last, `blk_bytes_i` is ignored.
- R6: `chk_valid_o` is high for exactly the one cycle that follows the acceptance of a last block. In that cycle, `chk_o` holds the finished sum.
- R7: Blocks accepted in one mode leave the other mode's sum unchanged.
- R8: `dec_in_o` equals `mix_i` XOR 1 (bit 0 flipped) when `tag_call_i` is high, and equals `mix_i` otherwise.
- R9: A `tag_valid_i` in decrypt mode makes `vld_o` high on the next cycle. In that same cycle, `pass_o` is 1 exactly when `tag_data_i` equals the decrypt sum.
- R10: `pass_o` keeps its value until the next start or the next decrypt-mode tag. A `tag_valid_i` in encrypt mode raises no `vld_o` and leaves `pass_o` alone.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start_i | input | 1 | New-message strobe |
| mode_dec_i | input | 1 | 0 encrypt, 1 decrypt |
| blk_valid_i | input | 1 | Block present |
| blk_last_i | input | 1 | Final message block |
| blk_bytes_i | input | 4 | Valid bytes of a final block, 0 meaning full |
| blk_data_i | input | 128 | Plaintext or recovered plaintext block |
| mix_i | input | 128 | Mixing-layer output toward the decryption core |
| tag_call_i | input | 1 | Current call is the tag-producing one |
| dec_in_o | output | 128 | Value steered into the decryption core |
| tag_valid_i | input | 1 | Decryption-core output for the tag block present |
| tag_data_i | input | 128 | Decryption-core output for the tag block |
| chk_o | output | 128 | Sum of the selected mode (the extra final block) |
| chk_valid_o | output | 1 | Sum is final |
| vld_o | output | 1 | Verification result present |
| pass_o | output | 1 | Verification passed, held |

## Verification
The bench aims at the padding boundaries: one data byte, five data bytes, fifteen data bytes, and a byte count of zero on a last block. A design that miscounts the marker position, or that keeps stale bytes past it, produces a wrong sum. The bench also sends a byte count on a non-last block, which catches a design that pads in the middle of a message. Interleaving the two modes exposes a shared or cross-written sum. The bench tests a start strobe in the same cycle as a block, a mismatched tag differing in a single bit, and a tag offered in encrypt mode. These show, respectively, a design that lets data leak past a clear, one that compares only part of the word, and one that overwrites the held verdict.

// File: rtl/cv_pkg.sv
// Shared types for the checksum/verify unit.
// Assumes one encrypt sum and one decrypt sum.
package cv_pkg;
    typedef enum logic {
        MODE_ENC = 1'b0,
        MODE_DEC = 1'b1
    } mode_e;

    localparam int NUM_SUMS = 2;
endpackage

// File: rtl/cv_pad.sv
// Byte-wise pad stage: on a short last block, keeps the data bytes, writes the
// marker byte 8'h80 after them and zeroes the rest. Byte 0 is the most
// significant byte. Assumes BLK_W is a multiple of 8.
module cv_pad #(
    parameter int BLK_W = 128,
    localparam int NBYTES = BLK_W / 8,
    localparam int CNT_W = $clog2(NBYTES)
) (
    input  logic [BLK_W-1:0] blk_i,
    input  logic             last_i,
    input  logic [CNT_W-1:0] bytes_i,
    output logic [BLK_W-1:0] blk_o
);
    logic full;

    // A block is left untouched unless it is last and short
    assign full = !last_i || (bytes_i == '0);

    for (genvar g = 0; g < NBYTES; g++) begin : g_byte
        localparam logic [CNT_W-1:0] BI = CNT_W'(g);
        localparam int HI = BLK_W - 1 - 8 * g;
        // Per-byte select: data, marker or zero
        assign blk_o[HI -: 8] = (full || (BI < bytes_i)) ? blk_i[HI -: 8] :
                                (BI == bytes_i)          ? 8'h80 : 8'h00;
    end
endmodule

// File: rtl/cv_accum.sv
// One XOR accumulator. Clear has priority over enable.
// Assumes the caller gates en_i.
module cv_accum #(
    parameter int BLK_W = 128
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr_i,
    input  logic             en_i,
    input  logic [BLK_W-1:0] blk_i,
    output logic [BLK_W-1:0] sum_o
);
    // Fold the incoming block into the running sum
    always_ff @(posedge clk) begin
        if (!rst_n || clr_i) begin
            sum_o <= '0;
        end else if (en_i) begin
            sum_o <= sum_o ^ blk_i;
        end
    end
endmodule

// File: rtl/cv_verify.sv
// Tag comparator. Registers a full-width equality result with a one-cycle
// valid pulse and holds the verdict until cleared. Assumes go_i is already
// gated to decrypt mode.
module cv_verify #(
    parameter int BLK_W = 128
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr_i,
    input  logic             go_i,
    input  logic [BLK_W-1:0] tag_i,
    input  logic [BLK_W-1:0] ref_i,
    output logic             vld_o,
    output logic             pass_o
);
    // Capture the comparison and pulse valid
    always_ff @(posedge clk) begin
        if (!rst_n || clr_i) begin
            vld_o  <= 1'b0;
            pass_o <= 1'b0;
        end else begin
            vld_o <= go_i;
            if (go_i) begin
                pass_o <= (tag_i == ref_i);
            end
        end
    end
endmodule

// File: rtl/cksum_verify.sv
// Checksum and tag verification unit. Pads a short final block, keeps
// separate encrypt and decrypt XOR sums, flags the finished sum, flips bit 0
// of the mixing output for the tag call, and checks the tag-block output of
// the decryption core against the decrypt sum. Assumes the tag arrives at
// least one cycle after the last block.
module cksum_verify
    import cv_pkg::*;
#(
    parameter int BLK_W = 128,
    localparam int NBYTES = BLK_W / 8,
    localparam int CNT_W = $clog2(NBYTES)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_i,
    input  logic             mode_dec_i,
    input  logic             blk_valid_i,
    input  logic             blk_last_i,
    input  logic [CNT_W-1:0] blk_bytes_i,
    input  logic [BLK_W-1:0] blk_data_i,
    input  logic [BLK_W-1:0] mix_i,
    input  logic             tag_call_i,
    output logic [BLK_W-1:0] dec_in_o,
    input  logic             tag_valid_i,
    input  logic [BLK_W-1:0] tag_data_i,
    output logic [BLK_W-1:0] chk_o,
    output logic             chk_valid_o,
    output logic             vld_o,
    output logic             pass_o
);
    mode_e            cur_mode;
    logic [BLK_W-1:0] padded;
    logic [BLK_W-1:0] sums [NUM_SUMS];
    logic             accept;
    logic             tag_go;

    assign cur_mode = mode_e'(mode_dec_i);
    assign accept   = blk_valid_i && !start_i;
    assign tag_go   = tag_valid_i && !start_i && (cur_mode == MODE_DEC);

    cv_pad #(.BLK_W(BLK_W)) u_pad (
        .blk_i   (blk_data_i),
        .last_i  (blk_last_i),
        .bytes_i (blk_bytes_i),
        .blk_o   (padded)
    );

    for (genvar s = 0; s < NUM_SUMS; s++) begin : g_sum
        localparam mode_e SM = (s == 0) ? MODE_ENC : MODE_DEC;
        cv_accum #(.BLK_W(BLK_W)) u_acc (
            .clk   (clk),
            .rst_n (rst_n),
            .clr_i (start_i),
            .en_i  (accept && (cur_mode == SM)),
            .blk_i (padded),
            .sum_o (sums[s])
        );
    end

    // Show the sum of the selected mode
    assign chk_o = sums[mode_dec_i];

    // Steer the tag call into the decryption core with bit 0 flipped
    assign dec_in_o = tag_call_i ? (mix_i ^ BLK_W'(1)) : mix_i;

    // Flag the cycle after the final block is folded in
    always_ff @(posedge clk) begin
        if (!rst_n || start_i) begin
            chk_valid_o <= 1'b0;
        end else begin
            chk_valid_o <= blk_valid_i && blk_last_i;
        end
    end

    cv_verify #(.BLK_W(BLK_W)) u_ver (
        .clk    (clk),
        .rst_n  (rst_n),
        .clr_i  (start_i),
        .go_i   (tag_go),
        .tag_i  (tag_data_i),
        .ref_i  (sums[1]),
        .vld_o  (vld_o),
        .pass_o (pass_o)
    );
endmodule

// File: rtl/cv_checker.sv
// Property checker for cksum_verify, bound to every instance.
module cv_checker #(
    parameter int BLK_W = 128
) (
    input logic             clk,
    input logic             rst_n,
    input logic             start_i,
    input logic             mode_dec_i,
    input logic             blk_valid_i,
    input logic             blk_last_i,
    input logic             tag_valid_i,
    input logic [BLK_W-1:0] chk_o,
    input logic             chk_valid_o,
    input logic             vld_o,
    input logic             pass_o
);
    // R2
    start_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
        start_i |=> (chk_o == '0 && !pass_o && !vld_o && !chk_valid_o));

    // R6
    chk_valid_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
        chk_valid_o |-> $past(blk_valid_i && blk_last_i && !start_i));

    // R9
    vld_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
        vld_o |-> $past(tag_valid_i && mode_dec_i && !start_i));

    // R10
    pass_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!start_i && !(tag_valid_i && mode_dec_i)) |=> $stable(pass_o));
endmodule

bind cksum_verify cv_checker #(.BLK_W(BLK_W)) u_cv_checker (
    .clk         (clk),
    .rst_n       (rst_n),
    .start_i     (start_i),
    .mode_dec_i  (mode_dec_i),
    .blk_valid_i (blk_valid_i),
    .blk_last_i  (blk_last_i),
    .tag_valid_i (tag_valid_i),
    .chk_o       (chk_o),
    .chk_valid_o (chk_valid_o),
    .vld_o       (vld_o),
    .pass_o      (pass_o)
);

// File: tb/tb_cksum_verify.sv
module tb_cksum_verify;
    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         start_i = 1'b0;
    logic         mode_dec_i = 1'b0;
    logic         blk_valid_i = 1'b0;
    logic         blk_last_i = 1'b0;
    logic [3:0]   blk_bytes_i = '0;
    logic [127:0] blk_data_i = '0;
    logic [127:0] mix_i = '0;
    logic         tag_call_i = 1'b0;
    logic [127:0] dec_in_o;
    logic         tag_valid_i = 1'b0;
    logic [127:0] tag_data_i = '0;
    logic [127:0] chk_o;
    logic         chk_valid_o;
    logic         vld_o;
    logic         pass_o;

    int n_run = 0;
    int n_fail = 0;
    bit done = 0;

    always #5 clk = ~clk;

    cksum_verify dut (.*);

    task automatic check(input string req, input logic [127:0] act, input logic [127:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [127:0] bpad(input logic [127:0] d, input int n, input bit last);
        logic [127:0] keep;
        if (!last || n == 0) return d;
        keep = ~(128'h0) << (128 - 8 * n);
        return (d & keep) | (128'h80 << (120 - 8 * n));
    endfunction

    // Drive one block at a negedge; returns one negedge after capture
    task automatic send(input logic [127:0] d, input bit last, input int n);
        blk_valid_i = 1'b1; blk_last_i = last; blk_bytes_i = 4'(n); blk_data_i = d;
        @(negedge clk);
        blk_valid_i = 1'b0; blk_last_i = 1'b0; blk_bytes_i = '0;
    endtask

    task automatic do_start();
        start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
    endtask

    task automatic send_tag(input logic [127:0] t);
        tag_valid_i = 1'b1; tag_data_i = t;
        @(negedge clk);
        tag_valid_i = 1'b0;
    endtask

    task automatic t_reset();
        check("R1 chk", chk_o, '0);
        check("R1 chk_valid", 128'(chk_valid_o), 0);
        check("R1 vld", 128'(vld_o), 0);
        check("R1 pass", 128'(pass_o), 0);
    endtask

    task automatic t_full_enc();
        logic [127:0] a = 128'h0123_4567_89ab_cdef_fedc_ba98_7654_3210;
        logic [127:0] b = 128'hdead_beef_0000_1111_2222_3333_4444_5555;
        logic [127:0] c = 128'h8000_0000_0000_0000_0000_0000_0000_0001;
        mode_dec_i = 1'b0;
        do_start();
        send(a, 0, 7);                  // R5 bytes ignored on non-last
        check("R5 non-last unpadded", chk_o, a);
        check("R6 no flag mid-message", 128'(chk_valid_o), 0);
        send(b, 0, 0);
        send(c, 1, 0);                  // R5 zero count = full
        check("R3 R5 full sum", chk_o, a ^ b ^ c);
        check("R6 flag high", 128'(chk_valid_o), 1);
        @(negedge clk);
        check("R6 flag one cycle", 128'(chk_valid_o), 0);
    endtask

    task automatic t_pad(input int n);
        logic [127:0] d = 128'hffee_ddcc_bbaa_9988_7766_5544_3322_1100;
        mode_dec_i = 1'b0;
        do_start();
        send(128'h5, 0, 0);
        send(d, 1, n);
        check($sformatf("R4 pad n=%0d", n), chk_o, 128'h5 ^ bpad(d, n, 1));
    endtask

    task automatic t_independent();
        logic [127:0] e = 128'h1111_2222_3333_4444_5555_6666_7777_8888;
        logic [127:0] f = 128'habcd_0000_0000_0000_0000_0000_0000_1234;
        do_start();
        mode_dec_i = 1'b0; send(e, 0, 0);
        mode_dec_i = 1'b1; send(f, 1, 2);
        check("R7 dec sum alone", chk_o, bpad(f, 2, 1));
        mode_dec_i = 1'b0;
        #1;
        check("R7 enc sum untouched", chk_o, e);
    endtask

    task automatic t_verify();
        logic [127:0] p = 128'h0f0f_0f0f_1234_5678_9abc_def0_aaaa_5555;
        logic [127:0] q = 128'h7777_0000_1111_0000_2222_0000_3333_0000;
        logic [127:0] s;
        mode_dec_i = 1'b1;
        do_start();
        send(p, 0, 0);
        send(q, 1, 9);
        s = p ^ bpad(q, 9, 1);
        @(negedge clk);
        send_tag(s);
        check("R9 vld pulse", 128'(vld_o), 1);
        check("R9 pass match", 128'(pass_o), 1);
        @(negedge clk);
        check("R9 vld one cycle", 128'(vld_o), 0);
        check("R10 pass held", 128'(pass_o), 1);
        mode_dec_i = 1'b0;
        send_tag(~s);
        check("R10 enc tag no vld", 128'(vld_o), 0);
        check("R10 enc tag pass kept", 128'(pass_o), 1);
        mode_dec_i = 1'b1;
        send_tag(s ^ 128'h1);
        check("R9 vld on mismatch", 128'(vld_o), 1);
        check("R9 one-bit mismatch fails", 128'(pass_o), 0);
    endtask

    task automatic t_start_priority();
        mode_dec_i = 1'b1;
        start_i = 1'b1;
        blk_valid_i = 1'b1; blk_last_i = 1'b1; blk_data_i = 128'hffff;
        tag_valid_i = 1'b1; tag_data_i = '0;
        @(negedge clk);
        start_i = 1'b0; blk_valid_i = 1'b0; blk_last_i = 1'b0; tag_valid_i = 1'b0;
        check("R2 block discarded", chk_o, '0);
        check("R2 no flag", 128'(chk_valid_o), 0);
        check("R2 no vld", 128'(vld_o), 0);
        check("R2 pass cleared", 128'(pass_o), 0);
    endtask

    task automatic t_dec_in();
        mix_i = 128'hcafe_0000_0000_0000_0000_0000_0000_00f0;
        tag_call_i = 1'b0;
        #1;
        check("R8 pass-through", dec_in_o, mix_i);
        tag_call_i = 1'b1;
        #1;
        check("R8 bit0 flipped", dec_in_o, 128'hcafe_0000_0000_0000_0000_0000_0000_00f1);
        tag_call_i = 1'b0;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_full_enc();
        t_pad(1);
        t_pad(5);
        t_pad(15);
        t_independent();
        t_verify();
        t_start_priority();
        t_dec_in();
        if (!done) begin
            done = 1;
            $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1;
            n_run++;
            n_fail++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end
endmodule